// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Access Controller

This block is the master side of a three-wire serial EEPROM link for a part organised as 64 words of 16 bits. A host pulses `start` with an operation code, a word address and, for writes, a data word. The block then runs the complete bit-level exchange on the chip-select, shift-clock and serial-data lines. It returns a one-cycle `done` pulse together with the read word or an error flag. Three operations are supported. A word read returns 16 bits. A standalone write-enable command unlocks programming. A word write always runs its own write-enable command first, then writes the word and waits for the device to report that programming has finished.

Every line change happens on a step boundary, and a step lasts `PHASE_CYC` system clocks. The shift clock therefore runs at the system clock divided by `2*PHASE_CYC`. Chip select stays high while a command is being shifted. It drops, with one shift-clock pulse, between the write-enable and write commands and again after the write data. After the data it is raised once more, and the device's output is polled until it goes high. The number of poll steps is capped at `POLL_LIMIT`. When the cap is reached the access ends with an error.

Top module: `uwire_eeprom_ctrl`

## Requirements
- R1: After reset, `ee_cs`, `ee_sck`, `ee_si`, `done` and `timeout_err` are 0 and `rdata` is 0.
- R2: The lines change only at step boundaries. Every step holds its line values for exactly `PHASE_CYC` clocks, and the first step appears in the cycle after the clock edge that accepts `start`.
- R3: A read (op code 0) first shows one step of cs=1, sck=0, si=0. It then sends 11 command bits, most significant first: 0,0,1,1,0 followed by addr[5] down to addr[0]. Each bit takes a step with sck=0 and then a step with sck=1, si holds the bit across both steps, and cs stays 1.
- R4: After the read command comes one step of cs=1, sck=0. Then 16 pairs of steps follow: a step with sck=1, then a step with sck=0. `ee_so` is sampled in the last clock of each sck=1 step, and the first bit sampled becomes rdata[0]. `rdata` changes only in the cycle where `done` is 1.
- R5: A write-enable (op code 1) sends 10 bits, most significant first: 0,1,0,0,1,1,0,0,0,0. Each bit uses the same low/high step pair as R3.
- R6: A write (op code 2) sends the R5 bits and then a gap of one step at cs=0,sck=0 and one at cs=0,sck=1. It then sends 0,1,0,1 followed by addr[5] down to addr[0], and then the 16 data bits with wdata[0] first, each as a low/high step pair with cs=1. The R6 gap follows the data.
- R7: After the second gap, poll steps with cs=1, sck=0, si=0 repeat. Polling stops after the first poll step in whose last clock `ee_so` is 1.
- R8: If `ee_so` is not seen high within `POLL_LIMIT` poll steps, the access ends with `timeout_err`=1, and `rdata` keeps the last word that was read. The next accepted start clears `timeout_err`.
- R9: Every access ends with one step of cs=1, sck=0, si=0. Then all three lines go low, and `done` is 1 for exactly that first idle cycle.
- R10: `start` is ignored while an access is running, and op code 3 is ignored at any time: no line moves and `done` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, sampled while idle |
| op | input | 2 | 0 read, 1 write-enable, 2 write, 3 reserved |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Word to write |
| rdata | output | DATA_W | Last word read |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Programming-complete poll ran out |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sck | output | 1 | EEPROM shift clock |
| ee_si | output | 1 | Serial data toward the EEPROM |
| ee_so | input | 1 | Serial data from the EEPROM |

## Verification
The bound checker enforces four properties on every cycle. No line value lasts less than one step while the block is busy. The data line never moves on a rising shift-clock edge. `done` is a single-cycle pulse that only appears with all lines low. `rdata` moves only with `done`. The order of the command bits, the least-significant-first assembly of the read word, the placement of the chip-select gaps, and the early exit from polling versus a timeout can only be shown by the bench's scenarios. Those scenarios compare the lines against a step list built from the requirements on every clock, and they play the device's data line from that same list.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WREN  = 2'd1,
    OP_WRITE = 2'd2,
    OP_RSVD  = 2'd3
  } uw_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_CMD_LO,
    ST_CMD_HI,
    ST_TURN,
    ST_RD_HI,
    ST_RD_LO,
    ST_WR_LO,
    ST_WR_HI,
    ST_GAP_LO,
    ST_GAP_HI,
    ST_POLL,
    ST_FIN
  } uw_state_e;

  typedef struct packed {
    logic cs;
    logic sk;
    logic si;
  } uw_lines_t;

endpackage

// File: rtl/uwire_step_timer.sv
module uwire_step_timer #(
  parameter int PHASE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic step_end
);

  generate
    if (PHASE_CYC <= 1) begin : g_single
      assign step_end = run;
    end else begin : g_count
      localparam int CW = $clog2(PHASE_CYC);
      localparam logic [CW-1:0] LAST = CW'(PHASE_CYC - 1);

      logic [CW-1:0] cnt_q;
      logic [CW-1:0] cnt_d;

      assign step_end = run && (cnt_q == LAST);

      always_comb begin
        if (!run || step_end) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
    end
  endgenerate

endmodule

// File: rtl/uwire_rx_collect.sv
module uwire_rx_collect #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic              bit_in,
  input  logic              publish,
  output logic [DATA_W-1:0] word
);

  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] word_q;

  // first bit in ends up in bit 0 after DATA_W samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (sample) begin
      sh_q <= {bit_in, sh_q[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (publish) begin
      word_q <= sh_q;
    end
  end

  assign word = word_q;

endmodule

// File: rtl/uwire_eeprom_ctrl.sv
module uwire_eeprom_ctrl
  import uwire_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int PHASE_CYC  = 2,
  parameter int POLL_LIMIT = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              timeout_err,
  output logic              ee_cs,
  output logic              ee_sck,
  output logic              ee_si,
  input  logic              ee_so
);

  localparam int CMD_W   = ADDR_W + 5;
  localparam int SHORT_W = ADDR_W + 4;
  localparam int CNT_MAX = (CMD_W > DATA_W) ? CMD_W : DATA_W;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int PW      = $clog2(POLL_LIMIT + 1);

  localparam logic [CNT_W-1:0] LEN_RD   = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] LEN_SH   = CNT_W'(SHORT_W);
  localparam logic [CNT_W-1:0] LEN_DATA = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] ONE_LEFT = CNT_W'(1);
  localparam logic [PW-1:0]    POLL_END = PW'(POLL_LIMIT - 1);

  // command words, left aligned so the current bit is always the MSB
  function automatic logic [CMD_W-1:0] read_word(input logic [ADDR_W-1:0] a);
    return {2'b00, 3'b110, a};
  endfunction

  function automatic logic [CMD_W-1:0] unlock_word();
    return {1'b0, 3'b100, 2'b11, {(ADDR_W-2){1'b0}}, 1'b0};
  endfunction

  function automatic logic [CMD_W-1:0] prog_word(input logic [ADDR_W-1:0] a);
    return {1'b0, 3'b101, a, 1'b0};
  endfunction

  function automatic uw_lines_t lines_of(input uw_state_e s, input logic cbit, input logic dbit);
    uw_lines_t l;
    case (s)
      ST_IDLE:   l = '{cs: 1'b0, sk: 1'b0, si: 1'b0};
      ST_CMD_LO: l = '{cs: 1'b1, sk: 1'b0, si: cbit};
      ST_CMD_HI: l = '{cs: 1'b1, sk: 1'b1, si: cbit};
      ST_RD_HI:  l = '{cs: 1'b1, sk: 1'b1, si: 1'b0};
      ST_WR_LO:  l = '{cs: 1'b1, sk: 1'b0, si: dbit};
      ST_WR_HI:  l = '{cs: 1'b1, sk: 1'b1, si: dbit};
      ST_GAP_LO: l = '{cs: 1'b0, sk: 1'b0, si: 1'b0};
      ST_GAP_HI: l = '{cs: 1'b0, sk: 1'b1, si: 1'b0};
      default:   l = '{cs: 1'b1, sk: 1'b0, si: 1'b0};
    endcase
    return l;
  endfunction

  uw_state_e         state_q, state_d;
  uw_op_e            op_q, op_d;
  uw_op_e            op_in;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic [DATA_W-1:0] wd_q, wd_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [PW-1:0]     poll_q, poll_d;
  logic              second_q, second_d;
  logic              err_q, err_d;
  logic              done_q, done_d;
  uw_lines_t         lines_q, lines_d;
  logic              busy;
  logic              step_end;
  logic              rx_sample;
  logic              rx_publish;

  assign op_in = uw_op_e'(op);
  assign busy  = (state_q != ST_IDLE);

  uwire_step_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .step_end (step_end)
  );

  uwire_rx_collect #(.DATA_W(DATA_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .sample  (rx_sample),
    .bit_in  (ee_so),
    .publish (rx_publish),
    .word    (rdata)
  );

  // next-state logic
  always_comb begin
    state_d    = state_q;
    op_d       = op_q;
    addr_d     = addr_q;
    cmd_d      = cmd_q;
    wd_d       = wd_q;
    cnt_d      = cnt_q;
    poll_d     = poll_q;
    second_d   = second_q;
    err_d      = err_q;
    done_d     = 1'b0;
    rx_sample  = 1'b0;
    rx_publish = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (start && (op_in != OP_RSVD)) begin
          op_d     = op_in;
          addr_d   = addr;
          wd_d     = wdata;
          err_d    = 1'b0;
          second_d = 1'b0;
          poll_d   = '0;
          if (op_in == OP_READ) begin
            cmd_d   = read_word(addr);
            cnt_d   = LEN_RD;
            state_d = ST_PRE;
          end else begin
            cmd_d   = unlock_word();
            cnt_d   = LEN_SH;
            state_d = ST_CMD_LO;
          end
        end
      end

      ST_PRE:    if (step_end) state_d = ST_CMD_LO;
      ST_CMD_LO: if (step_end) state_d = ST_CMD_HI;

      ST_CMD_HI: begin
        if (step_end) begin
          cmd_d = cmd_q << 1;
          cnt_d = cnt_q - 1'b1;
          if (cnt_q != ONE_LEFT) begin
            state_d = ST_CMD_LO;
          end else begin
            case (op_q)
              OP_READ: begin
                state_d = ST_TURN;
                cnt_d   = LEN_DATA;
              end
              OP_WREN: state_d = ST_FIN;
              default: begin
                if (!second_q) begin
                  state_d = ST_GAP_LO;
                end else begin
                  state_d = ST_WR_LO;
                  cnt_d   = LEN_DATA;
                end
              end
            endcase
          end
        end
      end

      ST_TURN: if (step_end) state_d = ST_RD_HI;

      ST_RD_HI: begin
        if (step_end) begin
          rx_sample = 1'b1;
          state_d   = ST_RD_LO;
        end
      end

      ST_RD_LO: begin
        if (step_end) begin
          cnt_d   = cnt_q - 1'b1;
          state_d = (cnt_q == ONE_LEFT) ? ST_FIN : ST_RD_HI;
        end
      end

      ST_WR_LO: if (step_end) state_d = ST_WR_HI;

      ST_WR_HI: begin
        if (step_end) begin
          wd_d    = wd_q >> 1;
          cnt_d   = cnt_q - 1'b1;
          state_d = (cnt_q == ONE_LEFT) ? ST_GAP_LO : ST_WR_LO;
        end
      end

      ST_GAP_LO: if (step_end) state_d = ST_GAP_HI;

      ST_GAP_HI: begin
        if (step_end) begin
          if (!second_q) begin
            second_d = 1'b1;
            cmd_d    = prog_word(addr_q);
            cnt_d    = LEN_SH;
            state_d  = ST_CMD_LO;
          end else begin
            poll_d  = '0;
            state_d = ST_POLL;
          end
        end
      end

      ST_POLL: begin
        if (step_end) begin
          if (ee_so) begin
            state_d = ST_FIN;
          end else if (poll_q == POLL_END) begin
            err_d   = 1'b1;
            state_d = ST_FIN;
          end else begin
            poll_d = poll_q + 1'b1;
          end
        end
      end

      ST_FIN: begin
        if (step_end) begin
          done_d     = 1'b1;
          rx_publish = (op_q == OP_READ);
          state_d    = ST_IDLE;
        end
      end

      default: state_d = ST_IDLE;
    endcase

    lines_d = lines_of(state_d, cmd_d[CMD_W-1], wd_d[0]);
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_READ;
      addr_q   <= '0;
      cmd_q    <= '0;
      wd_q     <= '0;
      cnt_q    <= '0;
      poll_q   <= '0;
      second_q <= 1'b0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
      lines_q  <= '0;
    end else begin
      state_q  <= state_d;
      op_q     <= op_d;
      addr_q   <= addr_d;
      cmd_q    <= cmd_d;
      wd_q     <= wd_d;
      cnt_q    <= cnt_d;
      poll_q   <= poll_d;
      second_q <= second_d;
      err_q    <= err_d;
      done_q   <= done_d;
      lines_q  <= lines_d;
    end
  end

  assign done        = done_q;
  assign timeout_err = err_q;
  assign ee_cs       = lines_q.cs;
  assign ee_sck      = lines_q.sk;
  assign ee_si       = lines_q.si;

endmodule

// File: rtl/uwire_eeprom_ctrl_chk.sv
module uwire_eeprom_ctrl_chk #(
  parameter int PHASE_CYC = 2,
  parameter int DATA_W    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              timeout_err,
  input logic [DATA_W-1:0] rdata,
  input logic              ee_cs,
  input logic              ee_sck,
  input logic              ee_si
);

  logic [2:0]  lines;
  logic [2:0]  prev_q;
  logic [15:0] run_q;
  logic        busy_q;

  assign lines = {ee_cs, ee_sck, ee_si};

  // run_q: how many cycles the previous line value was shown
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      run_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      prev_q <= lines;
      busy_q <= busy;
      if (lines != prev_q)   run_q <= 16'd1;
      else if (run_q != '1)  run_q <= run_q + 16'd1;
    end
  end

  assert_step_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (lines != prev_q)) |-> (run_q >= 16'(PHASE_CYC)));

  assert_si_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_sck) |-> $stable(ee_si));

  assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rdata));

  assert_err_in_fin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> (ee_cs && !ee_sck && !ee_si));

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ee_cs && !ee_sck && !ee_si));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind uwire_eeprom_ctrl uwire_eeprom_ctrl_chk #(
  .PHASE_CYC (PHASE_CYC),
  .DATA_W    (DATA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .timeout_err (timeout_err),
  .rdata       (rdata),
  .ee_cs       (ee_cs),
  .ee_sck      (ee_sck),
  .ee_si       (ee_si)
);

// File: tb/uwire_eeprom_ctrl_test.sv
module uwire_eeprom_ctrl_test;

  localparam int N   = 3;
  localparam int LIM = 6;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [1:0]  op;
  logic [5:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        done;
  logic        timeout_err;
  logic        ee_cs, ee_sck, ee_si, ee_so;

  int vectors;
  int miscompares;
  bit finished;

  logic [3:0] steps[$];   // {cs, sk, si, so-to-drive}
  string      tags[$];

  uwire_eeprom_ctrl #(
    .ADDR_W(6), .DATA_W(16), .PHASE_CYC(N), .POLL_LIMIT(LIM)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr),
    .wdata(wdata), .rdata(rdata), .done(done), .timeout_err(timeout_err),
    .ee_cs(ee_cs), .ee_sck(ee_sck), .ee_si(ee_si), .ee_so(ee_so)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic void push(input bit cs, input bit sk, input bit si,
                               input bit so, input string t);
    steps.push_back({cs, sk, si, so});
    tags.push_back(t);
  endfunction

  function automatic void push_bits(input logic [10:0] w, input int nb, input string t);
    for (int i = nb - 1; i >= 0; i--) begin
      push(1'b1, 1'b0, w[i], 1'b0, t);
      push(1'b1, 1'b1, w[i], 1'b0, t);
    end
  endfunction

  function automatic void plan_read(input logic [5:0] a, input logic [15:0] d);
    push(1'b1, 1'b0, 1'b0, 1'b0, "R3");
    push_bits({2'b00, 3'b110, a}, 11, "R2/R3");
    push(1'b1, 1'b0, 1'b0, 1'b0, "R4");
    for (int j = 0; j < 16; j++) begin
      push(1'b1, 1'b1, 1'b0, d[j], "R4");
      push(1'b1, 1'b0, 1'b0, 1'b0, "R4");
    end
    push(1'b1, 1'b0, 1'b0, 1'b0, "R9");
  endfunction

  function automatic void plan_unlock(input string t);
    push_bits({1'b0, 1'b0, 3'b100, 2'b11, 4'b0000}, 10, t);
  endfunction

  function automatic void plan_write(input logic [5:0] a, input logic [15:0] d, input int k);
    plan_unlock("R6");
    push(1'b0, 1'b0, 1'b0, 1'b0, "R6");
    push(1'b0, 1'b1, 1'b0, 1'b0, "R6");
    push_bits({1'b0, 1'b0, 3'b101, a}, 10, "R6");
    for (int j = 0; j < 16; j++) begin
      push(1'b1, 1'b0, d[j], 1'b0, "R6");
      push(1'b1, 1'b1, d[j], 1'b0, "R6");
    end
    push(1'b0, 1'b0, 1'b0, 1'b0, "R6");
    push(1'b0, 1'b1, 1'b0, 1'b0, "R6");
    for (int p = 0; p < LIM; p++) begin
      push(1'b1, 1'b0, 1'b0, (p >= k), (k >= LIM) ? "R8" : "R7");
      if (p >= k) break;
    end
    push(1'b1, 1'b0, 1'b0, 1'b0, "R9");
  endfunction

  task automatic launch(input logic [1:0] o, input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    start = 1'b1;
    op    = o;
    addr  = a;
    wdata = d;
  endtask

  // walk the planned steps on every clock, then check the ending
  task automatic play(input bit exp_err, input bit chk_rd, input logic [15:0] exp_rd,
                      input string rd_tag, input int poke_at);
    int idx;
    idx = 0;
    for (int s = 0; s < steps.size(); s++) begin
      for (int c = 0; c < N; c++) begin
        @(negedge clk);
        start = (idx == poke_at);
        if (idx == poke_at) op = 2'd0;
        ee_so = steps[s][0];
        chk(({ee_cs, ee_sck, ee_si} == steps[s][3:1]) && !done,
            (idx == poke_at + 1) ? "R10" : tags[s], "lines/done",
            {done, ee_cs, ee_sck, ee_si}, {1'b0, steps[s][3:1]});
        idx++;
      end
    end
    @(negedge clk);
    start = 1'b0;
    ee_so = 1'b0;
    chk(({ee_cs, ee_sck, ee_si} == 3'b000) && done, "R9", "end lines/done",
        {done, ee_cs, ee_sck, ee_si}, 4'b1000);
    chk(timeout_err == exp_err, "R8", "timeout_err", timeout_err, exp_err);
    if (chk_rd) chk(rdata == exp_rd, rd_tag, "rdata", rdata, exp_rd);
    @(negedge clk);
    chk(!done, "R9", "done one cycle", done, 0);
    steps.delete();
    tags.delete();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL R9: watchdog expired, actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    vectors = 0;
    miscompares = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    start = 1'b0;
    op    = 2'd0;
    addr  = '0;
    wdata = '0;
    ee_so = 1'b0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk({ee_cs, ee_sck, ee_si, done, timeout_err} == 5'b0, "R1", "lines in reset",
        {ee_cs, ee_sck, ee_si, done, timeout_err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({ee_cs, ee_sck, ee_si, done, timeout_err} == 5'b0, "R1", "lines after reset",
        {ee_cs, ee_sck, ee_si, done, timeout_err}, 0);
    chk(rdata == 16'h0, "R1", "rdata after reset", rdata, 0);

    // R3 R4: read, mixed pattern
    plan_read(6'h2A, 16'hB51C);
    launch(2'd0, 6'h2A, 16'h0);
    play(1'b0, 1'b1, 16'hB51C, "R4", -1);

    // R4: only the first sampled bit set -> rdata[0]
    plan_read(6'h15, 16'h0001);
    launch(2'd0, 6'h15, 16'h0);
    play(1'b0, 1'b1, 16'h0001, "R4", -1);

    // R5: standalone write-enable
    plan_unlock("R5");
    push(1'b1, 1'b0, 1'b0, 1'b0, "R9");
    launch(2'd1, 6'h00, 16'h0);
    play(1'b0, 1'b1, 16'h0001, "R4", -1);

    // R6 R7 R10: write, busy for two polls, start poked mid-access
    plan_write(6'h3F, 16'h8001, 2);
    launch(2'd2, 6'h3F, 16'h8001);
    play(1'b0, 1'b1, 16'h0001, "R6", 10);

    // R7: device ready at first poll
    plan_write(6'h00, 16'hA5A5, 0);
    launch(2'd2, 6'h00, 16'hA5A5);
    play(1'b0, 1'b0, 16'h0, "R7", -1);

    // R10: reserved op code does nothing
    launch(2'd3, 6'h11, 16'h1234);
    for (int i = 0; i < 4 * N; i++) begin
      @(negedge clk);
      start = 1'b0;
      chk(({ee_cs, ee_sck, ee_si} == 3'b000) && !done, "R10", "reserved op lines/done",
          {done, ee_cs, ee_sck, ee_si}, 0);
    end

    // R8: device never ready -> timeout, rdata keeps last read word
    plan_write(6'h09, 16'h5A5A, LIM);
    launch(2'd2, 6'h09, 16'h5A5A);
    play(1'b1, 1'b1, 16'h0001, "R8", -1);
    chk(timeout_err == 1'b1, "R8", "timeout_err held", timeout_err, 1);

    // R8: next accepted start clears the error; R4 all-ones read
    plan_read(6'h00, 16'hFFFF);
    launch(2'd0, 6'h00, 16'h0);
    play(1'b0, 1'b1, 16'hFFFF, "R4", -1);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule